// File: doc/BRIEF.md
# HI/LO Multiply-Accumulate Unit

This block multiplies two operands and folds the product into a pair of result registers, HI and LO, which together form one double-width accumulator. A single 3-bit operation code selects plain multiply, multiply-add or multiply-subtract, each in a signed or an unsigned flavour, or a direct write of HI or LO from operand A. A one-cycle start strobe launches an operation. Arithmetic operations run for a fixed number of cycles with `busy_o` high and finish with a one-cycle `done_o` pulse in the cycle the registers change.

Each half of the accumulator holds `DATA_W` bits and is presented on a port of `REG_W` bits as a sign-extended value. This lets a wider register file consume either half directly. Moves finish in one cycle and never raise `busy_o` or `done_o`. A strobe that arrives while an operation is in flight is dropped.

Top module: `hilo_mac`

## Requirements
- R1: While reset is held, and after it is released with no start strobe, HI and LO read zero and `busy_o` and `done_o` are low.
- R2: Operation code 0 is a signed multiply: both operands are sign-extended to 2*DATA_W bits and multiplied. LO takes product bits DATA_W-1:0 and HI takes bits 2*DATA_W-1:DATA_W.
- R3: Operation code 1 is an unsigned multiply: both operands are zero-extended before multiplying, and the halves are written as in R2.
- R4: Codes 2 (signed) and 3 (unsigned) add the product to the accumulator {HI, LO}, modulo 2^(2*DATA_W), and write the sum back to HI and LO.
- R5: Codes 4 (signed) and 5 (unsigned) subtract the product from {HI, LO}, modulo 2^(2*DATA_W), and write the difference back.
- R6: `hi_o` and `lo_o` carry the stored DATA_W-bit halves sign-extended to REG_W bits.
- R7: An accepted arithmetic start raises `busy_o` for exactly LATENCY cycles. The cycle after that, HI and LO show the result, `done_o` is high for that one cycle and `busy_o` is low. HI and LO do not change while `busy_o` is high.
- R8: A start strobe seen while `busy_o` is high is ignored: it neither alters the result in flight nor extends `busy_o`.
- R9: Code 6 writes operand A into HI and code 7 writes operand A into LO. The new value is visible in the cycle after the strobe, and neither `busy_o` nor `done_o` is raised.
- R10: A move strobe while `busy_o` is high leaves HI and LO untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle operation strobe |
| op_i | input | 3 | Operation code (see R2 to R5 and R9) |
| a_i | input | DATA_W | Operand A, also the data for moves |
| b_i | input | DATA_W | Operand B |
| hi_o | output | REG_W | HI half, sign-extended |
| lo_o | output | REG_W | LO half, sign-extended |
| busy_o | output | 1 | Arithmetic operation in flight |
| done_o | output | 1 | One-cycle pulse when an arithmetic result lands |

## Verification
The bench builds the unit with DATA_W=4, REG_W=8 and the default LATENCY of 4. This makes every operand pair (256 of them) reachable for all six arithmetic codes. Each pair starts from a HI/LO preset by moves, so negative products, carries across the HI/LO boundary and wrap-around of the accumulator are all covered. The 8-bit output ports show the sign extension of every 4-bit half. Separate sequences inject starts and moves in the middle of an operation and step through the busy window cycle by cycle.

// File: rtl/hilo_pkg.sv
package hilo_pkg;

  typedef enum logic [2:0] {
    OP_MUL_S  = 3'd0,
    OP_MUL_U  = 3'd1,
    OP_MADD_S = 3'd2,
    OP_MADD_U = 3'd3,
    OP_MSUB_S = 3'd4,
    OP_MSUB_U = 3'd5,
    OP_MOV_HI = 3'd6,
    OP_MOV_LO = 3'd7
  } hilo_op_e;

  typedef enum logic [1:0] {
    K_MUL  = 2'd0,
    K_MADD = 2'd1,
    K_MSUB = 2'd2
  } hilo_kind_e;

  function automatic logic op_is_arith(input logic [2:0] op);
    return op <= 3'(OP_MSUB_U);
  endfunction

  function automatic logic op_is_unsigned(input logic [2:0] op);
    return op[0];
  endfunction

  function automatic hilo_kind_e op_kind(input logic [2:0] op);
    hilo_kind_e k;
    case (op[2:1])
      2'd1:    k = K_MADD;
      2'd2:    k = K_MSUB;
      default: k = K_MUL;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/hilo_ctrl.sv
module hilo_ctrl
  import hilo_pkg::*;
#(
  parameter int LATENCY = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [2:0] op_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       fire_o,
  output logic       accept_o,
  output logic       wr_hi_o,
  output logic       wr_lo_o,
  output hilo_kind_e kind_o
);

  localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(LATENCY - 1);

  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  hilo_kind_e       kind_q;
  logic             idle_start;

  always_comb begin
    idle_start = start_i && !busy_q;
    accept_o   = idle_start && op_is_arith(op_i);
    wr_hi_o    = idle_start && (op_i == 3'(OP_MOV_HI));
    wr_lo_o    = idle_start && (op_i == 3'(OP_MOV_LO));
    fire_o     = busy_q && (cnt_q == '0);

    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (accept_o) begin
      busy_d = 1'b1;
      cnt_d  = CNT_INIT;
    end else if (fire_o) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d = cnt_q - 1'b1;
    end
    done_d = fire_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= K_MUL;
    end else if (accept_o) begin
      kind_q <= op_kind(op_i);
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign kind_o = kind_q;

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> ($past(busy_q) && !busy_q));

endmodule

// File: rtl/hilo_mul.sv
module hilo_mul #(
  parameter int DATA_W = 32,
  parameter bit PIPE   = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic                uns_i,
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   b_i,
  output logic [2*DATA_W-1:0] prod_o
);

  localparam int PW = 2 * DATA_W;

  logic [DATA_W-1:0] a_q, b_q;
  logic              uns_q;
  logic [PW-1:0]     ea, eb, prod_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      uns_q <= 1'b0;
    end else if (load_i) begin
      a_q   <= a_i;
      b_q   <= b_i;
      uns_q <= uns_i;
    end
  end

  always_comb begin
    ea     = uns_q ? {{DATA_W{1'b0}}, a_q} : {{DATA_W{a_q[DATA_W-1]}}, a_q};
    eb     = uns_q ? {{DATA_W{1'b0}}, b_q} : {{DATA_W{b_q[DATA_W-1]}}, b_q};
    prod_c = ea * eb;
  end

  generate
    if (PIPE) begin : g_pipe
      logic [PW-1:0] prod_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prod_q <= '0;
        else        prod_q <= prod_c;
      end
      assign prod_o = prod_q;
    end else begin : g_comb
      assign prod_o = prod_c;
    end
  endgenerate

endmodule

// File: rtl/hilo_regs.sv
module hilo_regs
  import hilo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fire_i,
  input  hilo_kind_e          kind_i,
  input  logic [2*DATA_W-1:0] prod_i,
  input  logic                wr_hi_i,
  input  logic                wr_lo_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [REG_W-1:0]    hi_o,
  output logic [REG_W-1:0]    lo_o
);

  localparam int PW = 2 * DATA_W;

  logic [DATA_W-1:0] hi_q, lo_q, hi_d, lo_d;
  logic [PW-1:0]     acc, res;
  logic              en;

  always_comb begin
    acc = {hi_q, lo_q};
    case (kind_i)
      K_MADD:  res = acc + prod_i;
      K_MSUB:  res = acc - prod_i;
      default: res = prod_i;
    endcase
    hi_d = hi_q;
    lo_d = lo_q;
    if (fire_i) begin
      hi_d = res[PW-1:DATA_W];
      lo_d = res[DATA_W-1:0];
    end
    if (wr_hi_i) hi_d = wdata_i;
    if (wr_lo_i) lo_d = wdata_i;
    en = fire_i || wr_hi_i || wr_lo_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (en) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  generate
    if (REG_W > DATA_W) begin : g_sext
      assign hi_o = {{(REG_W-DATA_W){hi_q[DATA_W-1]}}, hi_q};
      assign lo_o = {{(REG_W-DATA_W){lo_q[DATA_W-1]}}, lo_q};
    end else begin : g_flat
      assign hi_o = hi_q;
      assign lo_o = lo_q;
    end
  endgenerate

endmodule

// File: rtl/hilo_mac.sv
module hilo_mac
  import hilo_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int REG_W   = 64,
  parameter int LATENCY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [REG_W-1:0]  hi_o,
  output logic [REG_W-1:0]  lo_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam bit PIPE = (LATENCY > 1);

  logic [1:0]          rst_sync_q;
  logic                rst_int_n;
  logic                fire, accept, wr_hi, wr_lo;
  hilo_kind_e          kind;
  logic [2*DATA_W-1:0] prod;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  hilo_ctrl #(.LATENCY(LATENCY)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start_i  (start_i),
    .op_i     (op_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .fire_o   (fire),
    .accept_o (accept),
    .wr_hi_o  (wr_hi),
    .wr_lo_o  (wr_lo),
    .kind_o   (kind)
  );

  hilo_mul #(.DATA_W(DATA_W), .PIPE(PIPE)) u_mul (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load_i (accept),
    .uns_i  (op_is_unsigned(op_i)),
    .a_i    (a_i),
    .b_i    (b_i),
    .prod_o (prod)
  );

  hilo_regs #(.DATA_W(DATA_W), .REG_W(REG_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .fire_i  (fire),
    .kind_i  (kind),
    .prod_i  (prod),
    .wr_hi_i (wr_hi),
    .wr_lo_i (wr_lo),
    .wdata_i (a_i),
    .hi_o    (hi_o),
    .lo_o    (lo_o)
  );

  // R7
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (start_i && !busy_o && op_is_arith(op_i)) |=> busy_o);

  // R8 R10
  hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    busy_o |=> (done_o || ($stable(hi_o) && $stable(lo_o))));

  // R9
  move_lo_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (start_i && !busy_o && op_i == 3'(OP_MOV_LO)) |=>
      ($signed(lo_o) == $signed($past(a_i)) && !done_o && !busy_o));

  // R9
  move_hi_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (start_i && !busy_o && op_i == 3'(OP_MOV_HI)) |=>
      ($signed(hi_o) == $signed($past(a_i)) && !done_o && !busy_o));

endmodule

// File: tb/tb_hilo_mac.sv
`timescale 1ns/1ps
module tb_hilo_mac;

  localparam int W  = 4;
  localparam int RW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [2:0]    op = 3'd0;
  logic [W-1:0]  a = '0, b = '0;
  logic [RW-1:0] hi, lo;
  logic          busy, done;

  int checks = 0;
  int fails  = 0;
  int exp_hi = 0, exp_lo = 0;

  always #4 clk = ~clk;

  hilo_mac #(.DATA_W(W), .REG_W(RW), .LATENCY(4)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op),
    .a_i(a), .b_i(b), .hi_o(hi), .lo_o(lo), .busy_o(busy), .done_o(done)
  );

  function automatic int sx(input int v);
    return (v & 8) ? ((v & 15) | 8'hF0) : (v & 15);
  endfunction

  function automatic int sval(input int v);
    return (v & 8) ? (v & 15) - 16 : (v & 15);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  task automatic chk_regs(input string tag);
    chk(hi == RW'(sx(exp_hi)), tag, hi, sx(exp_hi));
    chk(lo == RW'(sx(exp_lo)), tag, lo, sx(exp_lo));
  endtask

  task automatic model(input int o, input int x, input int y);
    int p, acc, r;
    p   = (o & 1) ? (x * y) : (sval(x) * sval(y));
    acc = exp_hi * 16 + exp_lo;
    case (o >> 1)
      1:       r = acc + p;
      2:       r = acc - p;
      default: r = p;
    endcase
    r = r & 255;
    exp_hi = r >> 4;
    exp_lo = r & 15;
  endtask

  task automatic issue(input int o, input int x, input int y);
    @(negedge clk);
    start = 1'b1; op = 3'(o); a = W'(x); b = W'(y);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic move(input bit to_hi, input int x);
    issue(to_hi ? 6 : 7, x, 0);
    if (to_hi) exp_hi = x & 15; else exp_lo = x & 15;
  endtask

  task automatic run_arith(input int o, input int x, input int y, input string tag);
    issue(o, x, y);
    repeat (4) @(negedge clk);
    model(o, x, y);
    chk(done && !busy, tag, {done, busy}, 2'b10);
    chk_regs(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(hi == 0 && lo == 0 && !busy && !done, "R1 in reset", {hi, lo}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 after release
    chk(hi == 0 && lo == 0 && !busy && !done, "R1 after release", {hi, lo}, 0);

    // R9: move LO then HI, one cycle, no busy/done
    issue(7, 10, 0);
    exp_lo = 10;
    chk(!busy && !done, "R9 move flags", {busy, done}, 0);
    chk(lo == 8'hFA, "R9 R6 move LO", lo, 8'hFA);
    issue(6, 3, 0);
    exp_hi = 3;
    chk(hi == 8'h03, "R9 move HI", hi, 8'h03);

    // R7: cycle-by-cycle timing of an unsigned multiply 3*5
    issue(1, 3, 5);
    for (int i = 0; i < 4; i++) begin
      chk(busy && !done, "R7 busy window", {busy, done}, 2'b10);
      chk(hi == 8'h03 && lo == 8'hFA, "R7 hold while busy", {hi, lo}, 16'h03FA);
      if (i < 3) @(negedge clk);
    end
    @(negedge clk);
    model(1, 3, 5);
    chk(done && !busy, "R7 done pulse", {done, busy}, 2'b10);
    chk_regs("R3 R7 result");
    @(negedge clk);
    chk(!done && !busy, "R7 done one cycle", {done, busy}, 0);

    // R8: start while busy is dropped
    move(1, 1); move(0, 2);
    issue(2, 2, 3);
    start = 1'b1; op = 3'd5; a = 4'd7; b = 4'd7;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    model(2, 2, 3);
    chk(done, "R8 done on time", done, 1);
    chk_regs("R8 R4 result unaffected");
    @(negedge clk);
    chk(!busy && !done, "R8 no extra busy", {busy, done}, 0);

    // R10: move while busy is dropped
    move(1, 0); move(0, 0);
    issue(0, 7, 6);
    start = 1'b1; op = 3'd6; a = 4'd5;
    @(negedge clk);
    start = 1'b0;
    chk(hi == 8'h00, "R10 HI untouched mid-op", hi, 0);
    repeat (3) @(negedge clk);
    model(0, 7, 6);
    chk_regs("R10 R2 result");

    // R2-R6: exhaustive sweep over operand pairs and all arithmetic codes
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        move(1, x ^ y);
        move(0, (y + 3) & 15);
        run_arith(2, x, y, "R4 signed madd R6");
        run_arith(5, x, y, "R5 unsigned msub R6");
        run_arith(0, x, y, "R2 signed mul R6");
        run_arith(3, x, y, "R4 unsigned madd");
        run_arith(4, x, y, "R5 signed msub");
        run_arith(1, x, y, "R3 unsigned mul");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule